// File: doc/BRIEF.md
# Register-List Stack Push Sequencer

This block carries out a function-entry instruction that saves a chosen set of general registers onto a descending stack. It takes the raw 32-bit instruction word as two halfwords. It checks the fixed opcode bits and picks out a 12-bit register-select list, a 5-bit frame size and an optional element-pointer load. It then writes one word per selected register. Each word goes to the current stack pointer minus four, and the stack pointer moves down by four after each write.

When the register writes are finished, the block subtracts the frame size from the stack pointer. In the extended form it then loads the element pointer. The value comes from the new stack pointer or from an immediate given on the extension-word input. The surrounding core supplies register data through a read port indexed by list position. The core also holds the architectural stack and element pointers and updates them from the write strobes.

Top module: `push_seq`

## Requirements
- R1: A `start` pulse is accepted only while idle and only for a legal word. A legal word has `instr[31:22]` = 0000011110, and `instr[4:0]` is either 00001 (plain form) or `instr[2:0]` = 011 (element-pointer form, with the source code in `instr[4:3]`). Any other word leaves `busy`, `mem_req` and `done` low.
- R2: List bit 11 is `instr[16]`, list bits 10..0 are `instr[15:5]`, and the frame size is `instr[21:17]`, zero-extended.
- R3: Selected registers are stored highest list index first. Each store puts `rf_data` for `rf_idx` at address SP−4.
- R4: A store request holds its address and data until `mem_ack`. The stack pointer drops by four only on an acknowledged store, and each selected register is written exactly once.
- R5: After the stores, SP is lowered by the frame size through `sp_we`/`sp_out`.
- R6: In the element-pointer form the element pointer is loaded after the frame allocation. The source code is 00 for the new SP, 01 for sign-extended `ext_word[15:0]`, 10 for `ext_word[15:0]` shifted left by 16, and 11 for all of `ext_word`.
- R7: With every store acknowledged at once, `busy` lasts N+1 cycles in the plain form and N+2 cycles in the element-pointer form, where N is the number of selected registers. `done` is a single-cycle pulse in the last busy cycle.
- R8: An empty list performs no stores and still allocates the frame.
- R9: A `start` while busy is ignored. The running sequence finishes with its own results and one `done`.
- R10: After reset `busy`, `mem_req`, `sp_we`, `ep_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin executing `instr` |
| instr | input | 32 | Instruction, first halfword in bits 31:16 |
| ext_word | input | 32 | Immediate for the element-pointer load |
| sp_in | input | 32 | Stack pointer at start |
| rf_idx | output | 4 | List index of the register being read |
| rf_data | input | 32 | Register contents for `rf_idx` |
| mem_req | output | 1 | Word store request |
| mem_addr | output | 32 | Store address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Store accepted this cycle |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_out | output | 32 | New stack pointer value |
| ep_we | output | 1 | Element pointer write strobe |
| ep_out | output | 32 | New element pointer value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of the sequence |

## Verification
The assertions assume that `rf_data` depends only on `rf_idx` while a request is pending. The request-hold check relies on this. They also assume that `mem_ack` means something only while `mem_req` is high. The bench derives register data combinationally from the index. It raises acknowledge only in answer to a pending request, after a configurable number of wait cycles. `start` changes only between edges.

// File: rtl/push_seq_pkg.sv
package push_seq_pkg;
    localparam int XLEN   = 32;
    localparam int LIST_W = 12;
    localparam int IDX_W  = $clog2(LIST_W);
    localparam int IMM_W  = 5;

    typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_ALLOC, ST_EPLD} st_e;
    typedef enum logic [1:0] {EP_FROM_SP, EP_SEXT16, EP_HI16, EP_FULL32} ep_src_e;

    typedef struct packed {
        st_e               st;
        logic [LIST_W-1:0] pend;
        logic [IMM_W-1:0]  imm;
        logic              ep_en;
        ep_src_e           src;
        logic [XLEN-1:0]   ext;
        logic [XLEN-1:0]   sp;
    } ctx_t;
endpackage

// File: rtl/push_decode.sv
module push_decode
    import push_seq_pkg::*;
(
    input  logic [31:0]       instr,
    output logic              legal,
    output logic [LIST_W-1:0] mask,
    output logic [IMM_W-1:0]  imm,
    output logic              ep_en,
    output ep_src_e           src
);
    localparam logic [9:0] OPC_HI = 10'b0000011110;
    logic op_ok, tail_plain, tail_ep;

    always_comb begin
        op_ok      = (instr[31:22] == OPC_HI);
        tail_plain = (instr[4:0] == 5'b00001);
        tail_ep    = (instr[2:0] == 3'b011);
        legal      = op_ok && (tail_plain || tail_ep);
        mask       = {instr[16], instr[15:5]};
        imm        = instr[21:17];
        ep_en      = tail_ep;
        src        = ep_src_e'(instr[4:3]);
    end
endmodule

// File: rtl/push_pick.sv
module push_pick #(
    parameter int W = 12,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/push_ep_sel.sv
module push_ep_sel
    import push_seq_pkg::*;
(
    input  ep_src_e         src,
    input  logic [XLEN-1:0] sp,
    input  logic [XLEN-1:0] ext,
    output logic [XLEN-1:0] val
);
    always_comb begin
        unique case (src)
            EP_FROM_SP: val = sp;
            EP_SEXT16:  val = {{(XLEN-16){ext[15]}}, ext[15:0]};
            EP_HI16:    val = {ext[15:0], 16'h0000};
            default:    val = ext;
        endcase
    end
endmodule

// File: rtl/push_seq.sv
module push_seq
    import push_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] instr,
    input  logic [31:0] ext_word,
    input  logic [31:0] sp_in,
    output logic [3:0]  rf_idx,
    input  logic [31:0] rf_data,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    output logic        sp_we,
    output logic [31:0] sp_out,
    output logic        ep_we,
    output logic [31:0] ep_out,
    output logic        busy,
    output logic        done
);
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

    ctx_t ctx_d, ctx_q;

    logic              dec_legal, dec_ep;
    logic [LIST_W-1:0] dec_mask;
    logic [IMM_W-1:0]  dec_imm;
    ep_src_e           dec_src;
    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic [XLEN-1:0]   ep_val;

    push_decode u_dec (
        .instr (instr),
        .legal (dec_legal),
        .mask  (dec_mask),
        .imm   (dec_imm),
        .ep_en (dec_ep),
        .src   (dec_src)
    );

    push_pick #(.W(LIST_W)) u_pick (
        .vec (ctx_q.pend),
        .any (pick_any),
        .idx (pick_idx)
    );

    push_ep_sel u_eps (
        .src (ctx_q.src),
        .sp  (ctx_q.sp),
        .ext (ctx_q.ext),
        .val (ep_val)
    );

    always_comb begin
        ctx_d   = ctx_q;
        mem_req = 1'b0;
        sp_we   = 1'b0;
        ep_we   = 1'b0;
        done    = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start && dec_legal) begin
                    ctx_d.pend  = dec_mask;
                    ctx_d.imm   = dec_imm;
                    ctx_d.ep_en = dec_ep;
                    ctx_d.src   = dec_src;
                    ctx_d.ext   = ext_word;
                    ctx_d.sp    = sp_in;
                    ctx_d.st    = (|dec_mask) ? ST_STORE : ST_ALLOC;
                end
            end
            ST_STORE: begin
                mem_req = pick_any;
                if (mem_ack && pick_any) begin
                    ctx_d.sp             = ctx_q.sp - WORD_BYTES;
                    ctx_d.pend[pick_idx] = 1'b0;
                    sp_we                = 1'b1;
                    if (ctx_d.pend == '0) ctx_d.st = ST_ALLOC;
                end
            end
            ST_ALLOC: begin
                ctx_d.sp = ctx_q.sp - XLEN'(ctx_q.imm);
                sp_we    = 1'b1;
                if (ctx_q.ep_en) begin
                    ctx_d.st = ST_EPLD;
                end else begin
                    done     = 1'b1;
                    ctx_d.st = ST_IDLE;
                end
            end
            default: begin
                ep_we    = 1'b1;
                done     = 1'b1;
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign rf_idx    = pick_idx;
    assign mem_addr  = ctx_q.sp - WORD_BYTES;
    assign mem_wdata = rf_data;
    assign sp_out    = ctx_d.sp;
    assign ep_out    = ep_val;
    assign busy      = (ctx_q.st != ST_IDLE);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
    // R3
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R6
    ep_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep_we |-> (done && $past(sp_we)));
    // R1
    legal_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && dec_legal) |=> busy);
    // R1
    illegal_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && dec_legal)) |=> !busy);
endmodule

// File: tb/sim_push_seq.sv
module sim_push_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0, ext_word = '0, sp_in = '0;
    logic [3:0]  rf_idx;
    logic [31:0] rf_data;
    logic        mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic        sp_we, ep_we, busy, done;
    logic [31:0] sp_out, ep_out;

    int checks = 0, fails = 0;
    int stall_cfg = 0, wcnt = 0;
    int log_n = 0, done_cnt = 0, busy_cyc = 0;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];
    logic [31:0] sp_model = '0, ep_model = '0;
    bit ep_seen = 0;

    always #10 clk = ~clk;

    assign rf_data = 32'h1000_0000 + {28'h0, rf_idx} * 32'h0101;

    push_seq u0 (.*);

    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= stall_cfg) begin mem_ack = 1'b1; wcnt = 0; end
            else begin mem_ack = 1'b0; wcnt++; end
        end else begin
            mem_ack = 1'b0; wcnt = 0;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack && log_n < 16) begin
            log_addr[log_n] = mem_addr; log_data[log_n] = mem_wdata; log_n++;
        end
        if (sp_we) sp_model = sp_out;
        if (ep_we) begin ep_model = ep_out; ep_seen = 1; end
        if (done) done_cnt++;
        if (busy) busy_cyc++;
    end

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [11:0] m, input logic [4:0] imm,
                                        input bit ep, input logic [1:0] form);
        return {10'b0000011110, imm, m[11], m[10:0], ep ? {form, 3'b011} : 5'b00001};
    endfunction

    task automatic clear_logs();
        log_n = 0; done_cnt = 0; busy_cyc = 0; ep_seen = 0;
    endtask

    // Runs one sequence and checks stores, SP, EP, timing against a reference walk.
    task automatic run_push(input logic [11:0] m, input logic [4:0] imm, input bit ep,
                            input logic [1:0] form, input logic [31:0] ext,
                            input logic [31:0] sp0, input int stall, input bit poke);
        int n = 0, k = 0;
        logic [31:0] sp_e = sp0, ep_e;
        stall_cfg = stall;
        clear_logs();
        sp_model = sp0;
        @(negedge clk);
        instr = mk(m, imm, ep, form); ext_word = ext; sp_in = sp0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            instr = mk(12'h00F, 5'd3, 1'b1, 2'b11); ext_word = 32'h5555_5555; sp_in = 32'h0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 400 && done_cnt == 0; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        for (int i = 11; i >= 0; i--) begin
            if (m[i]) begin
                sp_e = sp_e - 32'd4;
                if (k < log_n) begin
                    chk(log_addr[k] == sp_e, "R3 addr", log_addr[k], sp_e);
                    chk(log_data[k] == 32'h1000_0000 + i * 32'h0101, "R3 data",
                        log_data[k], 32'h1000_0000 + i * 32'h0101);
                end
                k++; n++;
            end
        end
        chk(log_n == n, (n == 0) ? "R8 store count" : "R4 store count", log_n, n);
        sp_e = sp_e - {27'h0, imm};
        chk(sp_model == sp_e, "R5 final sp", sp_model, sp_e);
        chk(done_cnt == 1, poke ? "R9 done count" : "R7 done count", done_cnt, 1);
        if (ep) begin
            case (form)
                2'b00: ep_e = sp_e;
                2'b01: ep_e = {{16{ext[15]}}, ext[15:0]};
                2'b10: ep_e = {ext[15:0], 16'h0};
                default: ep_e = ext;
            endcase
            chk(ep_seen && ep_model == ep_e, "R6 ep value", ep_model, ep_e);
        end else begin
            chk(!ep_seen, "R6 no ep load in plain form", {31'h0, ep_seen}, 0);
        end
        if (stall == 0)
            chk(busy_cyc == n + (ep ? 2 : 1), "R7 cycle count", busy_cyc, n + (ep ? 2 : 1));
    endtask

    task automatic run_illegal(input logic [31:0] w, input string tag);
        clear_logs();
        @(negedge clk);
        instr = w; start = 1'b1; sp_in = 32'h4000;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy_cyc == 0 && log_n == 0 && done_cnt == 0, tag, busy_cyc, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R10
        chk(!busy && !mem_req && !done && !sp_we && !ep_we, "R10 reset outputs",
            {27'h0, busy, mem_req, done, sp_we, ep_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 R3 R5 R7 plain sparse list
        run_push(12'hA51, 5'd12, 1'b0, 2'b00, 32'h0, 32'h0000_8000, 0, 1'b0);
        // R2 R4 full list, top bit from first halfword, stalled acks
        run_push(12'hFFF, 5'd31, 1'b0, 2'b00, 32'h0, 32'h0001_0000, 2, 1'b0);
        // R8 empty list
        run_push(12'h000, 5'd8, 1'b0, 2'b00, 32'h0, 32'h0000_2000, 0, 1'b0);
        // R6 each source
        run_push(12'h003, 5'd4, 1'b1, 2'b00, 32'h0, 32'h0000_3000, 0, 1'b0);
        run_push(12'h800, 5'd0, 1'b1, 2'b01, 32'h0000_8123, 32'h0000_3000, 0, 1'b0);
        run_push(12'h400, 5'd2, 1'b1, 2'b10, 32'hFFFF_1234, 32'h0000_3000, 0, 1'b0);
        run_push(12'h111, 5'd16, 1'b1, 2'b11, 32'hDEAD_BEEF, 32'h0000_3000, 1, 1'b0);
        run_push(12'h000, 5'd20, 1'b1, 2'b00, 32'h0, 32'h0000_0100, 0, 1'b0);
        // R1 illegal words
        run_illegal(32'h0F80_0001 ^ 32'h8000_0000, "R1 bad opcode");
        run_illegal(mk(12'h0FF, 5'd4, 1'b0, 2'b00) ^ 32'h0000_0003, "R1 bad tail");
        // R9 start while busy
        run_push(12'hC30, 5'd6, 1'b0, 2'b00, 32'h0, 32'h0000_5000, 3, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule